// File: doc/BRIEF.md
# MDIO Management Slave with In-Band Interrupt

This block is the device side of a two-wire serial management bus. It follows the management clock, which is its `clk`. It watches the data line for frames that carry its own 5-bit device address and serves a small register file over them. The file holds two fixed identifier words, a device control register and a device status register. The control register has an interrupt-enable bit and a test bit that forces an interrupt. The status register carries a sticky pending flag in its top bit, and a read of that register clears the flag.

An `evt_i` pulse latches an interrupt as pending. After each frame addressed to this device there is one released (quiet) bit period. In the bit period after that, the slave pulls the data line low if the interrupt is enabled and an interrupt is pending or forced. This lets the host learn of the interrupt without polling.

Frame format on the line, all fields sent MSB first:
- a run of 1s as preamble;
- start bits 0 then 1;
- a 2-bit opcode: 10 for read, 01 for write;
- a 5-bit device address;
- a 5-bit register address;
- two turnaround bits;
- 16 data bits.

The slave samples `mdio_i` on the rising edge of `clk`. The values it drives, and the enable for them, change on the rising edge.

Top module: `mdio_phy_slave`

## Requirements
- R1: Register 0x02 reads as parameter `ID_HI` and register 0x03 reads as `ID_LO`. Writes to either register are ignored.
- R2: Register 0x11 has bit 1 as interrupt enable and bit 0 as test-interrupt. Both bits are written by a write frame. All other bits of 0x11 read as 0.
- R3: Register 0x12 reads bit 15 as (pending OR test bit), and all its other bits read as 0. A matched read of 0x12 clears the pending flag at the end of the turnaround. If an event arrives in that same cycle, the flag stays set.
- R4: A one-cycle `evt_i` pulse sets the pending flag one cycle later. The flag then stays set until 0x12 is read.
- R5: While the test bit is 1, an interrupt is present even with no event. Clearing the test bit removes it.
- R6: In a matched read, the slave holds `mdio_oe` low for the first turnaround bit. It drives 0 for the second turnaround bit, then the 16 data bits MSB first. It releases the line in the quiet bit that follows the data. It never drives in any header, preamble or write period.
- R7: In the bit period after the quiet bit of a matched frame, the slave drives 0 (`mdio_oe`=1, `mdio_o`=0) exactly when the interrupt enable is 1 and (pending OR test bit) is 1.
- R8: A frame whose device address differs from `phy_addr` is ignored. It causes no drive, no register write, no clear of the pending flag and no interrupt slot.
- R9: A write frame whose turnaround bits are not 1 then 0 is aborted, and no register changes.
- R10: A read of any register address other than 0x02, 0x03, 0x11 or 0x12 returns 0x0000. Writes to such addresses have no effect.
- R11: A frame whose opcode is 00 or 11 is abandoned after the header. Nothing is driven and no register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Management clock; MDIO sampled on rising edge |
| rst_n | input | 1 | Active-low reset |
| phy_addr | input | 5 | This device's bus address |
| evt_i | input | 1 | One-cycle pulse requesting an interrupt |
| mdio_i | input | 1 | Data line as seen by the slave |
| mdio_o | output | 1 | Value driven onto the data line |
| mdio_oe | output | 1 | Drive enable for the data line |

## Verification
The embedded assertions check several rules on every cycle:
- an event always latches the pending flag;
- the flag stays set until a status read clears it;
- a write turnaround of 0 in its first bit aborts the frame;
- the control bits change only in the last bit of a matched write;
- the quiet bit is never driven;
- the interrupt slot is driven only when interrupts are enabled.

Only the bench scenarios can show the rest:
- the exact read word for each register;
- whether the interrupt slot appears after a given sequence of events, enables and reads;
- that mismatched and malformed frames leave the register state untouched.

The bench shows each of these by comparing the line against a behavioural model in every bit period.

// File: rtl/mdio_phy_slave.sv
module mdio_phy_slave #(
  parameter logic [15:0] ID_HI = 16'h4000,
  parameter logic [15:0] ID_LO = 16'h5013
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [4:0] phy_addr,
  input  logic       evt_i,
  input  logic       mdio_i,
  output logic       mdio_o,
  output logic       mdio_oe
);
  localparam logic [4:0] A_IDHI = 5'h02;
  localparam logic [4:0] A_IDLO = 5'h03;
  localparam logic [4:0] A_CTRL = 5'h11;
  localparam logic [4:0] A_STAT = 5'h12;

  typedef enum logic [2:0] {S_IDLE, S_ST, S_HDR, S_TA, S_DATA, S_QUIET, S_SLOT} st_t;

  st_t         st;
  logic [3:0]  cnt;
  logic [10:0] hdr;
  logic        rd, hit;
  logic [4:0]  ra;
  logic [15:0] sh, rdata;
  logic        pend, inten, tint;

  wire [11:0] hfull     = {hdr, mdio_i};
  wire        op_ok     = (hfull[11:10] == 2'b10) || (hfull[11:10] == 2'b01);
  wire        stat_rd   = (st == S_TA) && (cnt == 4'd1) && rd && hit && (ra == A_STAT);
  wire        wr_commit = (st == S_DATA) && (cnt == 4'd15) && !rd && hit;
  wire [15:0] wdata     = {sh[14:0], mdio_i};
  wire        irq_on    = inten && (pend || tint);

  always_comb begin
    case (ra)
      A_IDHI:  rdata = ID_HI;
      A_IDLO:  rdata = ID_LO;
      A_CTRL:  rdata = {14'd0, inten, tint};
      A_STAT:  rdata = {pend || tint, 15'd0};
      default: rdata = 16'd0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= S_IDLE;
      cnt <= '0;
      hdr <= '0;
      rd  <= 1'b0;
      hit <= 1'b0;
      ra  <= '0;
      sh  <= '0;
    end else begin
      case (st)
        S_IDLE: if (!mdio_i) st <= S_ST;
        S_ST: begin
          st  <= mdio_i ? S_HDR : S_IDLE;
          cnt <= '0;
        end
        S_HDR: begin
          hdr <= hfull[10:0];
          cnt <= cnt + 4'd1;
          if (cnt == 4'd11) begin
            cnt <= '0;
            rd  <= hfull[11:10] == 2'b10;
            hit <= hfull[9:5] == phy_addr;
            ra  <= hfull[4:0];
            st  <= op_ok ? S_TA : S_IDLE;
          end
        end
        S_TA: begin
          if (cnt == 4'd0) begin
            cnt <= 4'd1;
            if (!rd && !mdio_i) st <= S_IDLE;
          end else begin
            cnt <= '0;
            if (!rd && mdio_i) st <= S_IDLE;
            else begin
              st <= S_DATA;
              sh <= rd ? rdata : 16'd0;
            end
          end
        end
        S_DATA: begin
          sh  <= rd ? {sh[14:0], 1'b0} : wdata;
          cnt <= cnt + 4'd1;
          if (cnt == 4'd15) st <= S_QUIET;
        end
        S_QUIET: st <= S_SLOT;
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend  <= 1'b0;
      inten <= 1'b0;
      tint  <= 1'b0;
    end else begin
      pend <= (pend && !stat_rd) || evt_i;
      if (wr_commit && ra == A_CTRL) {inten, tint} <= wdata[1:0];
    end
  end

  assign mdio_oe = hit && (((st == S_TA) && (cnt == 4'd1) && rd) ||
                           ((st == S_DATA) && rd) ||
                           ((st == S_SLOT) && irq_on));
  assign mdio_o  = (st == S_DATA) ? sh[15] : 1'b0;

  p_event_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
    evt_i |=> pend);
  p_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && !stat_rd) |=> pend);
  p_clear_on_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !evt_i) |=> !pend);
  p_quiet_released_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_QUIET) |-> !mdio_oe);
  p_slot_needs_enable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == S_SLOT) && mdio_oe) |-> (inten && !mdio_o));
  p_write_ta_abort_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == S_TA) && (cnt == 4'd0) && !rd && !mdio_i) |=> (st == S_IDLE));
  p_ctrl_only_on_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_commit |=> $stable({inten, tint}));
endmodule

// File: tb/mdio_phy_slave_tb.sv
module mdio_phy_slave_tb_top;
  localparam logic [15:0] IDH = 16'h4000;
  localparam logic [15:0] IDL = 16'h5013;
  localparam logic [4:0]  ME  = 5'h0B;

  logic clk = 1'b0, rst_n = 1'b0, evt_i = 1'b0, mdio_i = 1'b1;
  logic [4:0] phy_addr = ME;
  logic mdio_o, mdio_oe;
  int checks = 0, fails = 0;
  bit m_pend = 0, m_inten = 0, m_tint = 0;

  always #2 clk = ~clk;

  mdio_phy_slave #(.ID_HI(IDH), .ID_LO(IDL)) dut_i (
    .clk(clk), .rst_n(rst_n), .phy_addr(phy_addr), .evt_i(evt_i),
    .mdio_i(mdio_i), .mdio_o(mdio_o), .mdio_oe(mdio_oe));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic bitp(input logic v, input logic eoe, input logic eo, input logic ev, input string tag);
    @(negedge clk);
    mdio_i = v;
    evt_i  = ev;
    chk(mdio_oe === eoe, {tag, " oe"}, int'(mdio_oe), int'(eoe));
    if (eoe) chk(mdio_o === eo, {tag, " data"}, int'(mdio_o), int'(eo));
  endtask

  task automatic pulse_event();
    bitp(1'b1, 1'b0, 1'b0, 1'b1, "R4");
    bitp(1'b1, 1'b0, 1'b0, 1'b0, "R4");
    m_pend = 1;
  endtask

  function automatic logic [15:0] model_rd(input logic [4:0] r);
    case (r)
      5'h02:   return IDH;
      5'h03:   return IDL;
      5'h11:   return {14'd0, m_inten, m_tint};
      5'h12:   return {m_pend | m_tint, 15'd0};
      default: return 16'd0;
    endcase
  endfunction

  function automatic string rtag(input logic [4:0] r, input bit m);
    if (!m) return "R8";
    case (r)
      5'h02, 5'h03: return "R1";
      5'h11:        return "R2";
      5'h12:        return "R3";
      default:      return "R10";
    endcase
  endfunction

  task automatic frame(input logic [1:0] op, input logic [4:0] pa, input logic [4:0] r,
                       input logic [15:0] wd, input logic [1:0] ta, input bit ev_ta);
    bit m = (pa == ME);
    bit rdf = (op == 2'b10);
    bit good = (op == 2'b10) || (op == 2'b01);
    logic [11:0] h = {op, pa, r};
    logic [15:0] expv, got;
    string tg = rtag(r, m);
    got = '0;
    for (int i = 0; i < 4; i++) bitp(1'b1, 1'b0, 1'b0, 1'b0, "R6");
    bitp(1'b0, 1'b0, 1'b0, 1'b0, "R6");
    bitp(1'b1, 1'b0, 1'b0, 1'b0, "R6");
    for (int i = 11; i >= 0; i--) bitp(h[i], 1'b0, 1'b0, 1'b0, "R6");
    if (!good) begin
      for (int i = 0; i < 24; i++) bitp(1'b1, 1'b0, 1'b0, 1'b0, "R11");
      return;
    end
    if (!rdf && ta != 2'b10) begin
      bitp(ta[1], 1'b0, 1'b0, 1'b0, "R9");
      if (ta[1]) bitp(ta[0], 1'b0, 1'b0, 1'b0, "R9");
      for (int i = 0; i < 24; i++) bitp(1'b1, 1'b0, 1'b0, 1'b0, "R9");
      return;
    end
    expv = model_rd(r);
    bitp(rdf ? 1'b1 : ta[1], 1'b0, 1'b0, 1'b0, "R6");
    bitp(rdf ? 1'b1 : ta[0], rdf && m, 1'b0, ev_ta, "R6");
    if (rdf && m && r == 5'h12) m_pend = ev_ta;
    else if (ev_ta) m_pend = 1;
    for (int i = 15; i >= 0; i--) begin
      bitp(rdf ? 1'b1 : wd[i], rdf && m, expv[i], 1'b0, tg);
      got[i] = mdio_o;
    end
    if (!rdf && m && r == 5'h11) begin
      m_inten = wd[1];
      m_tint  = wd[0];
    end
    bitp(1'b1, 1'b0, 1'b0, 1'b0, "R6");
    bitp(1'b1, m && m_inten && (m_pend || m_tint), 1'b0, 1'b0, m ? "R7" : "R8");
    bitp(1'b1, 1'b0, 1'b0, 1'b0, "R7");
    if (rdf && m) chk(got === expv, {tg, " word"}, int'(got), int'(expv));
  endtask

  initial begin
    #(200000 * 4);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    bitp(1'b1, 1'b0, 1'b0, 1'b0, "R6");
    // R1 identifiers and write protection
    frame(2'b10, ME, 5'h02, 0, 2'b10, 0);
    frame(2'b10, ME, 5'h03, 0, 2'b10, 0);
    frame(2'b01, ME, 5'h02, 16'hFFFF, 2'b10, 0);
    frame(2'b10, ME, 5'h02, 0, 2'b10, 0);
    // R2 control, R5 test interrupt, R7 slot
    frame(2'b10, ME, 5'h11, 0, 2'b10, 0);
    frame(2'b01, ME, 5'h11, 16'hFFFF, 2'b10, 0);
    frame(2'b10, ME, 5'h11, 0, 2'b10, 0);
    frame(2'b10, ME, 5'h12, 0, 2'b10, 0);
    frame(2'b10, ME, 5'h12, 0, 2'b10, 0);
    frame(2'b01, ME, 5'h11, 16'h0002, 2'b10, 0);
    frame(2'b10, ME, 5'h12, 0, 2'b10, 0);
    // R4 sticky, R3 clear-on-read
    pulse_event();
    for (int i = 0; i < 5; i++) bitp(1'b1, 1'b0, 1'b0, 1'b0, "R4");
    frame(2'b10, ME, 5'h11, 0, 2'b10, 0);
    frame(2'b10, ME, 5'h12, 0, 2'b10, 0);
    frame(2'b10, ME, 5'h12, 0, 2'b10, 0);
    pulse_event();
    frame(2'b10, ME, 5'h12, 0, 2'b10, 1);
    frame(2'b10, ME, 5'h12, 0, 2'b10, 0);
    frame(2'b10, ME, 5'h12, 0, 2'b10, 1);
    frame(2'b10, ME, 5'h12, 0, 2'b10, 0);
    // R7 disabled interrupt
    frame(2'b01, ME, 5'h11, 16'h0000, 2'b10, 0);
    pulse_event();
    frame(2'b10, ME, 5'h11, 0, 2'b10, 0);
    frame(2'b10, ME, 5'h12, 0, 2'b10, 0);
    // R8 other address
    frame(2'b01, ME, 5'h11, 16'h0002, 2'b10, 0);
    pulse_event();
    frame(2'b10, 5'h0C, 5'h12, 0, 2'b10, 0);
    frame(2'b01, 5'h1B, 5'h11, 16'h0001, 2'b10, 0);
    frame(2'b10, ME, 5'h11, 0, 2'b10, 0);
    frame(2'b10, ME, 5'h12, 0, 2'b10, 0);
    // R9 bad write turnaround
    frame(2'b01, ME, 5'h11, 16'h0001, 2'b00, 0);
    frame(2'b01, ME, 5'h11, 16'h0001, 2'b11, 0);
    frame(2'b01, ME, 5'h11, 16'h0001, 2'b01, 0);
    frame(2'b10, ME, 5'h11, 0, 2'b10, 0);
    // R11 bad opcodes
    frame(2'b00, ME, 5'h11, 0, 2'b10, 0);
    frame(2'b11, ME, 5'h11, 0, 2'b10, 0);
    frame(2'b10, ME, 5'h11, 0, 2'b10, 0);
    // R10 unimplemented addresses
    frame(2'b01, ME, 5'h05, 16'hABCD, 2'b10, 0);
    frame(2'b10, ME, 5'h05, 0, 2'b10, 0);
    frame(2'b10, ME, 5'h1F, 0, 2'b10, 0);
    frame(2'b10, ME, 5'h11, 0, 2'b10, 0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule